// File: doc/BRIEF.md
# PS/2 Device-Side Serial Controller

This block is the device end of a two-wire PS/2 link. The device always generates the clock. It runs that clock from a programmable divider when it receives a frame that the host asks to send, and when it sends bytes from its own transmit buffer. Both lines are open-drain. The block therefore only drives pull-low enables, and it reads the wire levels back through two-flop synchronizers.

Frames have 11 bits: a start bit of 0, eight data bits sent least significant bit first, an odd parity bit, and a stop bit of 1.

When the host sends a frame, the device checks parity and the stop bit. It then pulls data low during one more clock pulse as the acknowledge, unless the acknowledge-check policy says to withhold it. When the device sends, it transmits a burst of `burst_i + 1` bytes, taken from buffer entries 0 upward. A host request to send interrupts a device burst. The byte that was cut off is sent again once the host frame is done.

Further controls are:
- an abort that empties the transmit queue;
- a software override of both lines;
- sticky completion flags with masked interrupts.

Top module: `ps2_dev_ctrl`

## Requirements
- R1: While `en_i` is 0 both pull-low enables stay 0. A host request is not clocked, and `tx_start_i` is ignored, so `tx_empty_o` stays 1.
- R2: A host frame is clocked by 11 device pulses. Bits are sampled at the end of each high half: pulses 1-8 give data LSB first, pulse 9 gives parity, and pulse 10 gives stop. `rx_data_o` then holds the byte, `rx_valid_o` pulses once, and `rx_done_o` sets. `rx_err_o` is 1 when the number of ones across data plus parity is even, or when stop is 0.
- R3: During pulse 11 the device pulls data low (the acknowledge). When `ack_chk_i` is 1 and the frame had an error, data stays released instead. When `ack_chk_i` is 0, the acknowledge is always given.
- R4: A device frame, read on each clock fall, is start 0, then data LSB first, then odd parity, then stop 1. Each low half of the clock lasts `CLK_HALF` cycles.
- R5: After `tx_start_i`, the device sends buffer entries 0 to `burst_i` in order. It then sets `tx_done_o`, returns `tx_empty_o` to 1, and rewinds its index.
- R6: A pulse on `buf_clear_i` stops a device burst within two cycles and sets `tx_empty_o`. It does not set `tx_done_o`. The next burst starts again at entry 0 and uses the buffer contents as they were.
- R7: While `ovr_i` is 1, `ps2_clk_oe_o` is the inverse of `ovr_clk_i` and `ps2_dat_oe_o` is the inverse of `ovr_dat_i`.
- R8: A request to send is made by the host holding the clock low, then pulling data low, then releasing the clock. During a burst it aborts the current byte and the host frame is received. The aborted byte and the rest of the burst are then sent.
- R9: `rx_done_o` and `tx_done_o` stay set until a one-cycle pulse on `rx_done_clr_i` or `tx_done_clr_i` clears them. `rx_irq_o` is `rx_done_o` AND `rx_ie_i`; `tx_irq_o` is `tx_done_o` AND `tx_ie_i`.
- R10: After reset, both lines are released, both flags and both interrupts are 0, and `tx_empty_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable |
| tx_ie_i | input | 1 | Transmit-done interrupt enable |
| rx_ie_i | input | 1 | Receive-done interrupt enable |
| burst_i | input | AW (4) | Bytes per burst, minus one |
| ack_chk_i | input | 1 | Withhold the acknowledge on frame error |
| buf_clear_i | input | 1 | Abort the burst and empty the queue (pulse) |
| ovr_i | input | 1 | Software takes over both lines |
| ovr_clk_i | input | 1 | Forced clock level (1 = released) |
| ovr_dat_i | input | 1 | Forced data level (1 = released) |
| buf_we_i | input | 1 | Buffer write strobe |
| buf_waddr_i | input | AW (4) | Buffer write address |
| buf_wdata_i | input | 8 | Buffer write data |
| tx_start_i | input | 1 | Start a burst (pulse) |
| rx_done_clr_i | input | 1 | Clear the receive-done flag (pulse) |
| tx_done_clr_i | input | 1 | Clear the transmit-done flag (pulse) |
| ps2_clk_i | input | 1 | Clock wire level |
| ps2_dat_i | input | 1 | Data wire level |
| ps2_clk_oe_o | output | 1 | Pull the clock wire low |
| ps2_dat_oe_o | output | 1 | Pull the data wire low |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new byte |
| rx_err_o | output | 1 | Last received frame had a parity or stop error |
| rx_done_o | output | 1 | Sticky receive-complete flag |
| tx_done_o | output | 1 | Sticky burst-complete flag |
| tx_empty_o | output | 1 | No burst pending |
| rx_irq_o | output | 1 | Receive interrupt |
| tx_irq_o | output | 1 | Transmit interrupt |

## Verification
The host model waits for each rise of the clock pull-low enable and acts on the following falling edge of the core clock. It drives its next data bit there or reads the data wire there, so it never depends on a fixed cycle count. The acknowledge is read on the same edge as the eleventh rise, because the device asserts it together with that clock pulse. The receive flag, data and error are due one register after the stop sample. The transmit-done flag is due one low half plus one register after the eleventh fall of the last byte. The checks wait `2*CLK_HALF` plus a small margin before reading either. Override and abort effects are combinational or one register deep, and they are sampled two core cycles after the stimulus.

// File: rtl/ps2_dev_pkg.sv
package ps2_dev_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FRAME_W = BYTE_W + 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INHIBIT,
    ST_LOAD,
    ST_TX,
    ST_RX,
    ST_ACK
  } eng_st_e;
endpackage

// File: rtl/ps2_dev_sync.sv
module ps2_dev_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/ps2_dev_txbuf.sv
module ps2_dev_txbuf
  import ps2_dev_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ps2_dev_engine.sv
module ps2_dev_engine
  import ps2_dev_pkg::*;
#(
  parameter  int unsigned CLK_HALF = 10000,
  parameter  int unsigned DEPTH    = 16,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned TW       = $clog2(CLK_HALF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ack_chk_i,
  input  logic [AW-1:0]     burst_i,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic              clk_s_i,
  input  logic              dat_s_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic              clk_oe_o,
  output logic              dat_oe_o,
  output logic              tx_empty_o,
  output logic              tx_done_o,
  output logic              rx_frame_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_err_o
);
  localparam logic [TW-1:0] TICK_END   = TW'(CLK_HALF - 1);
  localparam logic [TW-1:0] TICK_GUARD = TW'(3);
  localparam logic [3:0]    TX_LAST    = 4'(FRAME_W - 1);
  localparam logic [3:0]    RX_LAST    = 4'(FRAME_W - 2);

  eng_st_e              st_q;
  logic [TW-1:0]        tick_q;
  logic                 low_q, empty_q, ack_q, done_q, frame_q, err_q;
  logic [3:0]           bit_q;
  logic [FRAME_W-1:0]   shf_q;
  logic [AW-1:0]        idx_q;
  logic [BYTE_W-1:0]    byte_q;
  logic                 rx_bad;

  // shf_q[FRAME_W-1:2] holds data+parity after nine samples; dat_s_i is the stop bit
  assign rx_bad = (~^shf_q[FRAME_W-1:2]) | ~dat_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tick_q  <= '0;
      low_q   <= 1'b0;
      bit_q   <= '0;
      shf_q   <= '1;
      idx_q   <= '0;
      empty_q <= 1'b1;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      frame_q <= 1'b0;
      byte_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      frame_q <= 1'b0;
      if (!en_i) begin
        st_q   <= ST_IDLE;
        tick_q <= '0;
        low_q  <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (tick_q != TICK_GUARD) tick_q <= tick_q + TW'(1);
            else if (!clk_s_i) st_q <= ST_INHIBIT;
            else if (!empty_q && dat_s_i) st_q <= ST_LOAD;
          end
          ST_INHIBIT: begin
            if (clk_s_i) begin
              tick_q <= '0;
              bit_q  <= '0;
              if (!dat_s_i) begin
                st_q  <= ST_RX;
                low_q <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_LOAD: begin
            shf_q  <= {1'b1, ~^rd_data_i, rd_data_i, 1'b0};
            st_q   <= ST_TX;
            tick_q <= '0;
            low_q  <= 1'b0;
            bit_q  <= '0;
          end
          ST_TX: begin
            if (!low_q && tick_q >= TICK_GUARD && !clk_s_i) begin
              st_q   <= ST_IDLE;   // host took the line: retry this byte later
              tick_q <= '0;
            end else if (tick_q == TICK_END) begin
              tick_q <= '0;
              low_q  <= ~low_q;
              if (low_q) begin
                shf_q <= {1'b1, shf_q[FRAME_W-1:1]};
                bit_q <= bit_q + 4'd1;
                if (bit_q == TX_LAST) begin
                  if (idx_q == burst_i) begin
                    idx_q   <= '0;
                    empty_q <= 1'b1;
                    done_q  <= 1'b1;
                    st_q    <= ST_IDLE;
                  end else begin
                    idx_q <= idx_q + AW'(1);
                    st_q  <= ST_LOAD;
                  end
                end
              end
            end else begin
              tick_q <= tick_q + TW'(1);
            end
          end
          ST_RX: begin
            if (tick_q == TICK_END) begin
              tick_q <= '0;
              low_q  <= ~low_q;
              if (!low_q) begin
                shf_q <= {dat_s_i, shf_q[FRAME_W-1:1]};
                bit_q <= bit_q + 4'd1;
                if (bit_q == RX_LAST) begin
                  st_q    <= ST_ACK;
                  byte_q  <= shf_q[BYTE_W+1:2];
                  err_q   <= rx_bad;
                  ack_q   <= ~(ack_chk_i & rx_bad);
                  frame_q <= 1'b1;
                end
              end
            end else begin
              tick_q <= tick_q + TW'(1);
            end
          end
          ST_ACK: begin
            if (tick_q == TICK_END) begin
              tick_q <= '0;
              low_q  <= ~low_q;
              if (!low_q) st_q <= ST_IDLE;
            end else begin
              tick_q <= tick_q + TW'(1);
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
      if (clear_i) begin
        idx_q   <= '0;
        empty_q <= 1'b1;
        if (st_q == ST_TX || st_q == ST_LOAD) begin
          st_q   <= ST_IDLE;
          tick_q <= '0;
          low_q  <= 1'b0;
        end
      end else if (start_i && en_i && empty_q) begin
        empty_q <= 1'b0;
      end
    end
  end

  assign clk_oe_o   = low_q && (st_q == ST_TX || st_q == ST_RX || st_q == ST_ACK);
  assign dat_oe_o   = (st_q == ST_TX && !shf_q[0]) || (st_q == ST_ACK && ack_q);
  assign rd_addr_o  = idx_q;
  assign tx_empty_o = empty_q;
  assign tx_done_o  = done_q;
  assign rx_frame_o = frame_q;
  assign rx_byte_o  = byte_q;
  assign rx_err_o   = err_q;

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!clk_oe_o && !dat_oe_o));
  // R6
  clear_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (tx_empty_o && rd_addr_o == '0));
  // R5
  tx_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX) |-> !empty_q);
  // R3
  ack_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_o |-> (st_q == ST_ACK));
endmodule

// File: rtl/ps2_dev_ctrl.sv
module ps2_dev_ctrl
  import ps2_dev_pkg::*;
#(
  parameter  int unsigned CLK_HALF  = 10000,
  parameter  int unsigned BUF_DEPTH = 16,
  localparam int unsigned AW        = $clog2(BUF_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tx_ie_i,
  input  logic              rx_ie_i,
  input  logic [AW-1:0]     burst_i,
  input  logic              ack_chk_i,
  input  logic              buf_clear_i,
  input  logic              ovr_i,
  input  logic              ovr_clk_i,
  input  logic              ovr_dat_i,
  input  logic              buf_we_i,
  input  logic [AW-1:0]     buf_waddr_i,
  input  logic [BYTE_W-1:0] buf_wdata_i,
  input  logic              tx_start_i,
  input  logic              rx_done_clr_i,
  input  logic              tx_done_clr_i,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  output logic              ps2_clk_oe_o,
  output logic              ps2_dat_oe_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_err_o,
  output logic              rx_done_o,
  output logic              tx_done_o,
  output logic              tx_empty_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);
  logic [1:0]        line_s;
  logic [AW-1:0]     rd_addr;
  logic [BYTE_W-1:0] rd_data, rx_byte;
  logic              eng_clk_oe, eng_dat_oe, eng_done, eng_frame, eng_err;
  logic              rx_valid_q, rx_err_q, rx_done_q, tx_done_q;
  logic [BYTE_W-1:0] rx_data_q;

  ps2_dev_sync #(.WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ps2_dat_i, ps2_clk_i}),
    .q_o   (line_s)
  );

  ps2_dev_txbuf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk_i  (clk_i),
    .we_i   (buf_we_i),
    .waddr_i(buf_waddr_i),
    .wdata_i(buf_wdata_i),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  ps2_dev_engine #(.CLK_HALF(CLK_HALF), .DEPTH(BUF_DEPTH)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .ack_chk_i (ack_chk_i),
    .burst_i   (burst_i),
    .start_i   (tx_start_i),
    .clear_i   (buf_clear_i),
    .clk_s_i   (line_s[0]),
    .dat_s_i   (line_s[1]),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .clk_oe_o  (eng_clk_oe),
    .dat_oe_o  (eng_dat_oe),
    .tx_empty_o(tx_empty_o),
    .tx_done_o (eng_done),
    .rx_frame_o(eng_frame),
    .rx_byte_o (rx_byte),
    .rx_err_o  (eng_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
      rx_err_q   <= 1'b0;
      rx_done_q  <= 1'b0;
      tx_done_q  <= 1'b0;
    end else begin
      rx_valid_q <= eng_frame;
      if (eng_frame) begin
        rx_data_q <= rx_byte;
        rx_err_q  <= eng_err;
      end
      if (eng_frame)          rx_done_q <= 1'b1;
      else if (rx_done_clr_i) rx_done_q <= 1'b0;
      if (eng_done)           tx_done_q <= 1'b1;
      else if (tx_done_clr_i) tx_done_q <= 1'b0;
    end
  end

  // software override wins over the engine; force bit 1 means released
  assign ps2_clk_oe_o = ovr_i ? ~ovr_clk_i : eng_clk_oe;
  assign ps2_dat_oe_o = ovr_i ? ~ovr_dat_i : eng_dat_oe;
  assign rx_data_o    = rx_data_q;
  assign rx_valid_o   = rx_valid_q;
  assign rx_err_o     = rx_err_q;
  assign rx_done_o    = rx_done_q;
  assign tx_done_o    = tx_done_q;
  assign rx_irq_o     = rx_done_q & rx_ie_i;
  assign tx_irq_o     = tx_done_q & tx_ie_i;

  // R9
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_clr_i && !eng_frame) |=> !rx_done_o);
  // R2
  valid_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rx_done_o);
endmodule

// File: tb/ps2_dev_ctrl_test.sv
module ps2_dev_ctrl_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic en, tx_ie, rx_ie, ack_chk, buf_clear, ovr, ovr_clk, ovr_dat;
  logic buf_we, tx_start, rx_clr, tx_clr;
  logic [3:0] burst, waddr;
  logic [7:0] wdata;
  logic host_clk_pull, host_dat_pull;
  logic clk_oe, dat_oe, rx_valid, rx_err, rx_done, tx_done, tx_empty, rx_irq, tx_irq;
  logic [7:0] rx_data;
  logic clk_line, dat_line;

  assign clk_line = ~(clk_oe | host_clk_pull);
  assign dat_line = ~(dat_oe | host_dat_pull);

  ps2_dev_ctrl #(.CLK_HALF(HALF), .BUF_DEPTH(16)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .tx_ie_i(tx_ie), .rx_ie_i(rx_ie),
    .burst_i(burst), .ack_chk_i(ack_chk), .buf_clear_i(buf_clear), .ovr_i(ovr),
    .ovr_clk_i(ovr_clk), .ovr_dat_i(ovr_dat), .buf_we_i(buf_we), .buf_waddr_i(waddr),
    .buf_wdata_i(wdata), .tx_start_i(tx_start), .rx_done_clr_i(rx_clr),
    .tx_done_clr_i(tx_clr), .ps2_clk_i(clk_line), .ps2_dat_i(dat_line),
    .ps2_clk_oe_o(clk_oe), .ps2_dat_oe_o(dat_oe), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_err_o(rx_err), .rx_done_o(rx_done),
    .tx_done_o(tx_done), .tx_empty_o(tx_empty), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  int nchk = 0;
  int nerr = 0;
  int nvalid = 0;
  int cyc = 0;

  always @(posedge clk) begin
    if (rx_valid) nvalid++;
    cyc++;
    if (cyc == 190000) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  function automatic logic [7:0] bval(input int j);
    return 8'((j * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    logic prev;
    prev = clk_oe;
    forever begin
      @(negedge clk);
      if (clk_oe && !prev) break;
      prev = clk_oe;
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic read_frame(output logic [10:0] f);
    for (int i = 0; i < 11; i++) begin
      wait_fall();
      f[i] = dat_line;
    end
  endtask

  // request to send, then drive one host frame; returns whether the ack was given
  task automatic host_write(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                            output logic ack);
    logic [9:0] seq;
    seq = {~bad_stop, (~^d) ^ bad_par, d};
    host_clk_pull = 1'b1;
    repeat (20) @(negedge clk);
    host_dat_pull = 1'b1;
    repeat (4) @(negedge clk);
    host_clk_pull = 1'b0;
    for (int k = 0; k < 10; k++) begin
      wait_fall();
      host_dat_pull = ~seq[k];
    end
    wait_fall();
    host_dat_pull = 1'b0;
    ack = dat_oe;
    repeat (2 * HALF + 8) @(negedge clk);
  endtask

  logic [10:0] fr;
  logic ack;
  int n0, cnt, seen;

  initial begin
    en = 0; tx_ie = 0; rx_ie = 0; ack_chk = 0; buf_clear = 0; ovr = 0; ovr_clk = 1;
    ovr_dat = 1; buf_we = 0; tx_start = 0; rx_clr = 0; tx_clr = 0; burst = 0;
    waddr = 0; wdata = 0; host_clk_pull = 0; host_dat_pull = 0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(!clk_oe && !dat_oe, "R10 lines", {clk_oe, dat_oe}, 0);
    chk(!rx_done && !tx_done && !rx_irq && !tx_irq, "R10 flags",
        {rx_done, tx_done, rx_irq, tx_irq}, 0);
    chk(tx_empty, "R10 empty", tx_empty, 1);

    for (int j = 0; j < 16; j++) begin
      buf_we = 1; waddr = 4'(j); wdata = bval(j);
      @(negedge clk);
    end
    buf_we = 0;

    // R7 override, with the engine both disabled and enabled
    for (int e = 0; e < 2; e++) begin
      en = e[0];
      ovr = 1;
      for (int m = 0; m < 4; m++) begin
        ovr_clk = m[0]; ovr_dat = m[1];
        repeat (2) @(negedge clk);
        chk(clk_oe == ~ovr_clk && dat_oe == ~ovr_dat, "R7", {clk_oe, dat_oe},
            {~ovr_clk, ~ovr_dat});
      end
      ovr = 0; ovr_clk = 1; ovr_dat = 1;
    end
    en = 0;
    repeat (4) @(negedge clk);

    // R1 disabled: start ignored, request not clocked
    burst = 0;
    pulse(tx_start);
    host_clk_pull = 1;
    repeat (20) @(negedge clk);
    host_dat_pull = 1;
    repeat (4) @(negedge clk);
    host_clk_pull = 0;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (clk_oe || dat_oe) seen++;
    end
    chk(seen == 0, "R1 lines", seen, 0);
    chk(tx_empty, "R1 empty", tx_empty, 1);
    host_dat_pull = 0;
    repeat (10) @(negedge clk);
    en = 1;
    repeat (10) @(negedge clk);

    // R2/R3/R9 receive sweep over every byte value
    for (int d = 0; d < 256; d++) begin
      ack_chk = d[0];
      rx_ie = d[1];
      n0 = nvalid;
      host_write(8'(d), 0, 0, ack);
      chk(ack == 1'b1, "R3 ack", ack, 1);
      chk(rx_data == 8'(d), "R2 data", rx_data, d);
      chk(!rx_err, "R2 err", rx_err, 0);
      chk(nvalid == n0 + 1, "R2 valid", nvalid - n0, 1);
      repeat (10) @(negedge clk);
      chk(rx_done, "R9 sticky", rx_done, 1);
      chk(rx_irq == rx_ie, "R9 rx_irq", rx_irq, rx_ie);
      pulse(rx_clr);
      chk(!rx_done && !rx_irq, "R9 clear", {rx_done, rx_irq}, 0);
    end

    // R2/R3 error frames under both acknowledge policies
    for (int c = 0; c < 12; c++) begin
      ack_chk = c[0];
      host_write(8'(c * 19 + 3), c[1] | ~c[2], c[2], ack);
      chk(rx_err, "R2 error flag", rx_err, 1);
      chk(ack == ~ack_chk, "R3 withheld", ack, ~ack_chk);
      pulse(rx_clr);
    end
    ack_chk = 0;

    // R4/R5/R9 transmit sweep over every burst length
    for (int b = 0; b < 16; b++) begin
      burst = 4'(b);
      tx_ie = b[0];
      pulse(tx_start);
      chk(!tx_empty, "R5 pending", tx_empty, 0);
      for (int j = 0; j <= b; j++) begin
        read_frame(fr);
        chk(fr == {1'b1, ~^bval(j), bval(j), 1'b0}, "R4 frame", fr,
            {1'b1, ~^bval(j), bval(j), 1'b0});
      end
      repeat (2 * HALF + 6) @(negedge clk);
      chk(tx_done && tx_empty, "R5 done", {tx_done, tx_empty}, 3);
      chk(tx_irq == tx_ie, "R9 tx_irq", tx_irq, tx_ie);
      pulse(tx_clr);
      chk(!tx_done, "R9 tx clear", tx_done, 0);
    end

    // R4 low half length, then R6 abort
    burst = 5;
    pulse(tx_start);
    read_frame(fr);
    wait_fall();
    cnt = 0;
    while (clk_oe) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == HALF, "R4 low half", cnt, HALF);
    wait_fall();
    pulse(buf_clear);
    @(negedge clk);
    chk(tx_empty && !clk_oe && !dat_oe, "R6 abort", {tx_empty, clk_oe, dat_oe}, 4);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (clk_oe || dat_oe) seen++;
    end
    chk(seen == 0 && !tx_done, "R6 quiet", seen, 0);
    burst = 0;
    pulse(tx_start);
    read_frame(fr);
    chk(fr == {1'b1, ~^bval(0), bval(0), 1'b0}, "R6 rewind", fr,
        {1'b1, ~^bval(0), bval(0), 1'b0});
    repeat (2 * HALF + 6) @(negedge clk);
    pulse(tx_clr);

    // R8 host request during a burst
    burst = 2;
    pulse(tx_start);
    read_frame(fr);
    chk(fr[8:1] == bval(0), "R8 first", fr[8:1], bval(0));
    repeat (3) wait_fall();
    host_write(8'hA5, 0, 0, ack);
    chk(rx_data == 8'hA5 && ack, "R8 rx", rx_data, 8'hA5);
    for (int j = 1; j <= 2; j++) begin
      read_frame(fr);
      chk(fr == {1'b1, ~^bval(j), bval(j), 1'b0}, "R8 retry", fr,
          {1'b1, ~^bval(j), bval(j), 1'b0});
    end
    repeat (2 * HALF + 6) @(negedge clk);
    chk(tx_done && tx_empty, "R8 done", {tx_done, tx_empty}, 3);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule